// File: doc/BRIEF.md
# Per-Turn Command Store with Match Interrupts

This block sits behind a timing receiver and collects the commands that arrive during each beam revolution. Every command carries an 8-bit subaddress and an 8-bit data byte. The block writes the data byte into a 256-entry main RAM at the address given by the subaddress. A host CPU reads that RAM, and a small set of control registers, through a simple register port. A one-cycle turn pulse marks the boundary between messages. The block also keeps a 24-bit turn counter that the host can read together with the RAM.

Two select registers each name a subaddress and hold an 8-bit data mask. A command at a selected subaddress whose data shares a set bit with that mask raises the interrupt. The message in progress still completes. At the next turn boundary the main RAM freezes, and it stays frozen until the host acknowledges the interrupt. The host can also ask for one complete message to be copied into a separate snapshot RAM, which keeps that copy until the next request.

Host map (10-bit word address, region in bits 9:8):
- Region 0 is the main RAM and region 1 is the snapshot RAM; the subaddress is in bits 7:0.
- Region 2 holds the registers:
  - index 0 is control: bit 0 write enable, bit 1 interrupt enable, bit 2 dump request (writing 1 requests a dump; it reads back as dump busy), bit 3 short-ring mode.
  - index 1 is status: bit 0 interrupt pending, which a write of 1 clears; bit 1 dump done; bit 2 frozen; bit 3 dump busy.
  - index 2 is the latched turn count; any write to it clears the counter.
  - index 4+i is select channel i: subaddress in bits 7:0, mask in bits 15:8.

Host reads return data on `host_rdata` in the cycle after `host_re`.

Top module: `tms_turn_store`

## Requirements
- R1: A command accepted while the write-enable bit is set and the RAM is not frozen stores its data byte at main RAM address equal to its subaddress, and a later host read of region 0 at that subaddress returns it in bits 7:0.
- R2: While the write-enable bit (control bit 0) is clear, commands leave the main RAM unchanged.
- R3: With interrupt enable (control bit 1) set, a command whose subaddress equals a select channel's subaddress and whose data ANDed with that channel's mask is nonzero drives `irq` high from the next cycle. Status bit 0 then reads 1.
- R4: With interrupt enable clear, a matching command leaves `irq` low.
- R5: After an interrupt, the remaining commands of the current turn are still written. From the next turn pulse on, main RAM writes are blocked and status bit 2 reads 1. Writing 1 to status bit 0 resumes writing.
- R6: Interrupt pending stays set until the host clears it. A further match while it is pending creates no new request, so `irq` stays low after a single clear.
- R7: A dump request made mid-turn captures the commands of the next full turn into the snapshot RAM (region 1). Status reads 0x8 (busy) during that turn and 0x2 (done) after the closing turn pulse. Later turns do not alter the snapshot.
- R8: Each turn pulse advances the counter. The value read from register index 2 equals the number of turn pulses since reset or since the last write to that register.
- R9: Only the first 32 commands of a turn are accepted (8 when control bit 3 selects short-ring mode); later commands in the same turn are dropped.
- R10: A host read and a command write to the same main RAM address in the same cycle return the previous contents.
- R11: After reset, `irq` is low and the control, status and turn registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 10 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 32 | Read data, valid the cycle after host_re |
| cmd_valid | input | 1 | Command strobe |
| cmd_sub | input | 8 | Command subaddress |
| cmd_data | input | 8 | Command data byte |
| turn_tick | input | 1 | One-cycle turn boundary pulse |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
Each result has a fixed latency:
- A command is written into the RAM, and any pending flag is set, at the clock edge that samples its strobe. This means `irq` is visible half a cycle after that edge.
- A host read returns data at the edge after `host_re`.
- A freeze or a dump start takes effect for the command that shares a cycle with the next turn pulse.
- Dump done appears at the edge of the closing turn pulse.

The bench drives inputs at falling edges and samples `irq` at the next falling edge. Read results go through a queue that the monitor pops one falling edge after each read edge. Every read therefore observes state that already includes all earlier commands, and every expectation is aligned to these latencies.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int SUB_W   = 8;
  localparam int DAT_W   = 8;
  localparam int HDATA_W = 32;
  localparam int HADDR_W = SUB_W + 2;

  localparam int REG_CTL  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_TURN = 2;
  localparam int REG_SEL0 = 4;

  localparam int CTL_WREN  = 0;
  localparam int CTL_IRQEN = 1;
  localparam int CTL_DUMP  = 2;
  localparam int CTL_SHORT = 3;

  localparam int STAT_IRQ    = 0;
  localparam int STAT_DONE   = 1;
  localparam int STAT_FROZEN = 2;
  localparam int STAT_BUSY   = 3;

  typedef enum logic [1:0] {
    RGN_MAIN = 2'd0,
    RGN_SNAP = 2'd1,
    RGN_REGS = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  function automatic logic sel_hit(input logic [SUB_W-1:0] sub,
                                   input logic [SUB_W-1:0] sel,
                                   input logic [DAT_W-1:0] data,
                                   input logic [DAT_W-1:0] mask);
    return (sub == sel) && ((data & mask) != '0);
  endfunction
endpackage

// File: rtl/tms_dpram.sv
module tms_dpram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first: a same-cycle write is seen by the next read only
  always_ff @(posedge clk) begin
    q <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/tms_match.sv
module tms_match
  import tms_pkg::*;
#(
  parameter int NSEL = 2
) (
  input  logic [SUB_W-1:0]            cmd_sub,
  input  logic [DAT_W-1:0]            cmd_data,
  input  logic [NSEL-1:0][SUB_W-1:0]  sel_sub,
  input  logic [NSEL-1:0][DAT_W-1:0]  sel_mask,
  output logic [NSEL-1:0]             hit_vec,
  output logic                        hit
);
  for (genvar i = 0; i < NSEL; i++) begin : g_chan
    assign hit_vec[i] = sel_hit(cmd_sub, sel_sub[i], cmd_data, sel_mask[i]);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/tms_msg_seq.sv
module tms_msg_seq #(
  parameter int LONG_MAX  = 32,
  parameter int SHORT_MAX = 8,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             turn_tick,
  input  logic             cmd_valid,
  input  logic             short_mode,
  input  logic             match_hit,
  input  logic             irq_en,
  input  logic             irq_clr,
  input  logic             dump_req,
  output logic             accept,
  output logic             frozen_eff,
  output logic             snap_we,
  output logic             irq_pend,
  output logic             frozen,
  output logic             dump_busy,
  output logic             dump_done,
  output logic [CNT_W-1:0] msg_cnt
);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_MAX);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_MAX);

  logic [CNT_W-1:0] limit, cnt_base;
  logic arm_q, dpend_q, dact_q, capture, new_hit;

  assign limit    = short_mode ? LIM_S : LIM_L;
  assign cnt_base = turn_tick ? '0 : msg_cnt;
  assign accept   = cmd_valid && (cnt_base < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_cnt <= '0;
    else        msg_cnt <= cnt_base + CNT_W'(accept);
  end

  // interrupt request, armed freeze and freeze
  assign new_hit    = accept && match_hit && irq_en && !irq_pend;
  assign frozen_eff = frozen || (turn_tick && arm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
      arm_q    <= 1'b0;
      frozen   <= 1'b0;
    end else if (irq_clr) begin
      irq_pend <= 1'b0;
      arm_q    <= 1'b0;
      frozen   <= 1'b0;
    end else begin
      if (turn_tick && arm_q) begin
        frozen <= 1'b1;
        arm_q  <= 1'b0;
      end
      if (new_hit) begin
        irq_pend <= 1'b1;
        arm_q    <= 1'b1;
      end
    end
  end

  // snapshot dump: pending -> active for one whole turn -> done
  assign capture   = turn_tick ? dpend_q : dact_q;
  assign snap_we   = accept && capture;
  assign dump_busy = dpend_q || dact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpend_q   <= 1'b0;
      dact_q    <= 1'b0;
      dump_done <= 1'b0;
    end else begin
      if (turn_tick) begin
        if (dact_q) dump_done <= 1'b1;
        dact_q  <= dpend_q;
        dpend_q <= 1'b0;
      end
      if (dump_req) begin
        dpend_q   <= 1'b1;
        dump_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tms_turn_store.sv
module tms_turn_store
  import tms_pkg::*;
#(
  parameter int TURN_W    = 24,
  parameter int LONG_MAX  = 32,
  parameter int SHORT_MAX = 8,
  parameter int NSEL      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  input  logic               host_we,
  input  logic               host_re,
  output logic [HDATA_W-1:0] host_rdata,
  input  logic               cmd_valid,
  input  logic [SUB_W-1:0]   cmd_sub,
  input  logic [DAT_W-1:0]   cmd_data,
  input  logic               turn_tick,
  output logic               irq
);
  localparam int CNT_W = $clog2(LONG_MAX + 1);

  function automatic logic [TURN_W-1:0] turn_next(input logic [TURN_W-1:0] v);
    return v + TURN_W'(1);
  endfunction

  region_e             host_rgn, rd_rgn_q;
  logic [SUB_W-1:0]    reg_idx;
  logic                reg_wr, ctl_wr, stat_wr, turn_clr, irq_clr, dump_req;
  logic                wr_en_q, irq_en_q, short_q;
  logic [NSEL-1:0][SUB_W-1:0] sel_sub;
  logic [NSEL-1:0][DAT_W-1:0] sel_mask;
  logic [NSEL-1:0]     hit_vec;
  logic                match_hit;
  logic [TURN_W-1:0]   turn_cnt, turn_snap;
  logic                accept, frozen_eff, snap_we, irq_pend, frozen;
  logic                dump_busy, dump_done, main_we;
  logic [CNT_W-1:0]    msg_cnt;
  logic [DAT_W-1:0]    main_q, snap_q;
  logic [HDATA_W-1:0]  reg_val, reg_q;
  logic                wdata_unused;

  assign host_rgn = region_e'(host_addr[HADDR_W-1 -: 2]);
  assign reg_idx  = host_addr[SUB_W-1:0];
  assign reg_wr   = host_we && (host_rgn == RGN_REGS);
  assign ctl_wr   = reg_wr && (reg_idx == SUB_W'(REG_CTL));
  assign stat_wr  = reg_wr && (reg_idx == SUB_W'(REG_STAT));
  assign turn_clr = reg_wr && (reg_idx == SUB_W'(REG_TURN));
  assign irq_clr  = stat_wr && host_wdata[STAT_IRQ];
  assign dump_req = ctl_wr && host_wdata[CTL_DUMP];
  assign wdata_unused = ^host_wdata[HDATA_W-1:SUB_W+DAT_W];

  // control and select registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q  <= 1'b0;
      irq_en_q <= 1'b0;
      short_q  <= 1'b0;
      sel_sub  <= '0;
      sel_mask <= '0;
    end else begin
      if (ctl_wr) begin
        wr_en_q  <= host_wdata[CTL_WREN];
        irq_en_q <= host_wdata[CTL_IRQEN];
        short_q  <= host_wdata[CTL_SHORT];
      end
      for (int i = 0; i < NSEL; i++) begin
        if (reg_wr && (reg_idx == SUB_W'(REG_SEL0 + i))) begin
          sel_sub[i]  <= host_wdata[SUB_W-1:0];
          sel_mask[i] <= host_wdata[SUB_W +: DAT_W];
        end
      end
    end
  end

  // turn counter, latched at each boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_cnt  <= '0;
      turn_snap <= '0;
    end else if (turn_clr) begin
      turn_cnt  <= '0;
      turn_snap <= '0;
    end else if (turn_tick) begin
      turn_cnt  <= turn_next(turn_cnt);
      turn_snap <= turn_next(turn_cnt);
    end
  end

  tms_match #(.NSEL(NSEL)) u_match (
    .cmd_sub  (cmd_sub),
    .cmd_data (cmd_data),
    .sel_sub  (sel_sub),
    .sel_mask (sel_mask),
    .hit_vec  (hit_vec),
    .hit      (match_hit)
  );

  tms_msg_seq #(
    .LONG_MAX (LONG_MAX),
    .SHORT_MAX(SHORT_MAX),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .turn_tick (turn_tick),
    .cmd_valid (cmd_valid),
    .short_mode(short_q),
    .match_hit (match_hit),
    .irq_en    (irq_en_q),
    .irq_clr   (irq_clr),
    .dump_req  (dump_req),
    .accept    (accept),
    .frozen_eff(frozen_eff),
    .snap_we   (snap_we),
    .irq_pend  (irq_pend),
    .frozen    (frozen),
    .dump_busy (dump_busy),
    .dump_done (dump_done),
    .msg_cnt   (msg_cnt)
  );

  assign main_we = accept && wr_en_q && !frozen_eff;
  assign irq     = irq_pend;

  tms_dpram #(.AW(SUB_W), .DW(DAT_W)) u_main (
    .clk  (clk),
    .we   (main_we),
    .waddr(cmd_sub),
    .wdata(cmd_data),
    .raddr(host_addr[SUB_W-1:0]),
    .q    (main_q)
  );

  tms_dpram #(.AW(SUB_W), .DW(DAT_W)) u_snap (
    .clk  (clk),
    .we   (snap_we),
    .waddr(cmd_sub),
    .wdata(cmd_data),
    .raddr(host_addr[SUB_W-1:0]),
    .q    (snap_q)
  );

  // host register read view
  always_comb begin
    reg_val = '0;
    if (reg_idx == SUB_W'(REG_CTL)) begin
      reg_val[CTL_WREN]  = wr_en_q;
      reg_val[CTL_IRQEN] = irq_en_q;
      reg_val[CTL_DUMP]  = dump_busy;
      reg_val[CTL_SHORT] = short_q;
    end else if (reg_idx == SUB_W'(REG_STAT)) begin
      reg_val[STAT_IRQ]    = irq_pend;
      reg_val[STAT_DONE]   = dump_done;
      reg_val[STAT_FROZEN] = frozen;
      reg_val[STAT_BUSY]   = dump_busy;
    end else if (reg_idx == SUB_W'(REG_TURN)) begin
      reg_val[TURN_W-1:0] = turn_snap;
    end
    for (int i = 0; i < NSEL; i++) begin
      if (reg_idx == SUB_W'(REG_SEL0 + i))
        reg_val[SUB_W+DAT_W-1:0] = {sel_mask[i], sel_sub[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rgn_q <= RGN_NONE;
      reg_q    <= '0;
    end else if (host_re) begin
      rd_rgn_q <= host_rgn;
      reg_q    <= reg_val;
    end
  end

  always_comb begin
    unique case (rd_rgn_q)
      RGN_MAIN: host_rdata = HDATA_W'(main_q);
      RGN_SNAP: host_rdata = HDATA_W'(snap_q);
      RGN_REGS: host_rdata = reg_q;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tms_chk.sv
module tms_chk #(
  parameter int TURN_W = 24,
  parameter int CNT_W  = 6,
  parameter int LIMIT  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              match_hit,
  input logic              accept,
  input logic              irq_en,
  input logic              irq_clr,
  input logic              frozen,
  input logic              main_we,
  input logic              wr_en,
  input logic              turn_tick,
  input logic              turn_clr,
  input logic              dump_done,
  input logic [TURN_W-1:0] turn_cnt,
  input logic [CNT_W-1:0]  msg_cnt
);
  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(match_hit && accept && irq_en));

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R5
  frozen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !main_we);

  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_we |-> wr_en);

  // R7
  dump_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_done) |-> $past(turn_tick));

  // R8
  turn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_tick && !turn_clr) |=> (turn_cnt == $past(turn_cnt) + TURN_W'(1)));

  // R9
  msg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_cnt <= CNT_W'(LIMIT));
endmodule

bind tms_turn_store tms_chk #(
  .TURN_W(TURN_W),
  .CNT_W ($clog2(LONG_MAX + 1)),
  .LIMIT (LONG_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .match_hit(match_hit),
  .accept   (accept),
  .irq_en   (irq_en_q),
  .irq_clr  (irq_clr),
  .frozen   (frozen),
  .main_we  (main_we),
  .wr_en    (wr_en_q),
  .turn_tick(turn_tick),
  .turn_clr (turn_clr),
  .dump_done(dump_done),
  .turn_cnt (turn_cnt),
  .msg_cnt  (msg_cnt)
);

// File: tb/tb_tms_turn_store.sv
`timescale 1ns/1ps
module tb_tms_turn_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [31:0] host_rdata;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_sub = '0;
  logic [7:0]  cmd_data = '0;
  logic        turn_tick = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int n_ticks = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  tms_turn_store dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_sub(cmd_sub), .cmd_data(cmd_data),
    .turn_tick(turn_tick), .irq(irq)
  );

  localparam logic [9:0] A_CTL  = 10'h200;
  localparam logic [9:0] A_STAT = 10'h201;
  localparam logic [9:0] A_TURN = 10'h202;
  localparam logic [9:0] A_SEL0 = 10'h204;
  localparam logic [9:0] A_SEL1 = 10'h205;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results one falling edge after the read edge
  always @(posedge clk) rd_pend <= host_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", host_rdata, '0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwr(input logic [9:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    step();
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    host_addr = a; host_re = 1'b1;
    step();
    host_re = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] s, input logic [7:0] d);
    cmd_sub = s; cmd_data = d; cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic cmd_rd(input logic [7:0] s, input logic [7:0] d, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    cmd_sub = s; cmd_data = d; cmd_valid = 1'b1;
    host_addr = {2'b00, s}; host_re = 1'b1;
    step();
    cmd_valid = 1'b0; host_re = 1'b0;
  endtask

  task automatic tick();
    turn_tick = 1'b1;
    step();
    turn_tick = 1'b0;
    n_ticks++;
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", '0, '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R11 reset state
    check(irq === 1'b0, "R11 irq after reset", {31'b0, irq}, 0);
    hrd(A_CTL, 0, "R11 control");
    hrd(A_STAT, 0, "R11 status");
    hrd(A_TURN, 0, "R11 turn");

    // R1 basic store
    hwr(A_CTL, 32'h1);
    tick();
    cmd(8'h10, 8'hA5);
    cmd(8'h11, 8'h3C);
    hrd(10'h010, 32'hA5, "R1 sub 0x10");
    hrd(10'h011, 32'h3C, "R1 sub 0x11");

    // R10 same-cycle collision returns old value
    cmd_rd(8'h10, 8'h77, 32'hA5, "R10 old value");
    hrd(10'h010, 32'h77, "R10 new value after");

    // R2 write enable clear
    hwr(A_CTL, 32'h0);
    cmd(8'h10, 8'h11);
    hrd(10'h010, 32'h77, "R2 write disabled");
    hwr(A_CTL, 32'h1);

    // R9 long-ring limit of 32
    tick();
    for (int i = 0; i < 32; i++) cmd(8'(8'h40 + i), 8'(i + 1));
    cmd(8'h40, 8'hFF);
    hrd(10'h040, 32'h01, "R9 33rd command dropped");
    hrd(10'h05F, 32'h20, "R9 32nd command stored");
    // R9 short-ring limit of 8
    hwr(A_CTL, 32'h9);
    tick();
    for (int i = 0; i < 8; i++) cmd(8'(8'h60 + i), 8'(8'h20 + i));
    cmd(8'h60, 8'hFF);
    hrd(10'h060, 32'h20, "R9 short 9th dropped");
    hrd(10'h067, 32'h27, "R9 short 8th stored");
    hwr(A_CTL, 32'h1);

    // R8 turn counter
    hrd(A_TURN, 32'(n_ticks), "R8 turn count");
    hwr(A_TURN, 32'h0);
    n_ticks = 0;
    hrd(A_TURN, 0, "R8 cleared");
    tick();
    tick();
    hrd(A_TURN, 32'(n_ticks), "R8 after two turns");

    // R4 interrupt disabled
    hwr(A_SEL0, 32'h0C21);
    tick();
    cmd(8'h21, 8'h04);
    check(irq === 1'b0, "R4 no irq when disabled", {31'b0, irq}, 0);

    // R3 match with mask
    hwr(A_CTL, 32'h3);
    cmd(8'h21, 8'h03);
    check(irq === 1'b0, "R3 no mask overlap", {31'b0, irq}, 0);
    hwr(A_SEL1, 32'h8022);
    cmd(8'h22, 8'h81);
    check(irq === 1'b1, "R3 irq on channel 1", {31'b0, irq}, 1);
    hrd(A_STAT, 32'h1, "R3 status pending");

    // R5 freeze at boundary
    cmd(8'h30, 8'h55);
    hrd(10'h030, 32'h55, "R5 same turn still written");
    tick();
    cmd(8'h30, 8'h66);
    hrd(10'h030, 32'h55, "R5 frozen after boundary");
    hrd(A_STAT, 32'h5, "R5 status frozen");

    // R6 second match while pending
    cmd(8'h21, 8'h04);
    check(irq === 1'b1, "R6 irq stays set", {31'b0, irq}, 1);
    hwr(A_STAT, 32'h1);
    check(irq === 1'b0, "R6 single clear drops irq", {31'b0, irq}, 0);
    hrd(A_STAT, 32'h0, "R6 status cleared");
    cmd(8'h30, 8'h66);
    hrd(10'h030, 32'h66, "R5 writes resume");
    check(irq === 1'b0, "R6 no extra request", {31'b0, irq}, 0);

    // R7 dump of next full message
    hwr(A_CTL, 32'h1);
    cmd(8'h50, 8'h01);
    hwr(A_CTL, 32'h5);
    cmd(8'h50, 8'h02);
    tick();
    cmd(8'h50, 8'hA0);
    cmd(8'h52, 8'hA2);
    hrd(A_STAT, 32'h8, "R7 busy during dump");
    tick();
    hrd(A_STAT, 32'h2, "R7 done after boundary");
    hrd(10'h150, 32'hA0, "R7 snapshot sub 0x50");
    hrd(10'h152, 32'hA2, "R7 snapshot sub 0x52");
    cmd(8'h50, 8'hB0);
    tick();
    hrd(10'h150, 32'hA0, "R7 snapshot kept");
    hrd(10'h050, 32'hB0, "R1 main still updated");

    step();
    step();
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule